// File: doc/BRIEF.md
# Keystream Update and Output Pipeline

This block holds the secret state of a byte-oriented, permutation-based stream cipher and advances it in hardware. The state is a permutation of 0..N-1 held in an N-entry register array, together with the byte registers i, j, k, w and z. Software-visible framing, key absorption and the crush step live elsewhere. This block performs only three operations: state initialization, a whip of r state updates, and a drip that emits one keystream byte per update.

Each update first advances i by w. It then reads the array twice in a chain to form the new j. Next it forms k from i, the old k and the entry at the new j. Last, it exchanges the entries at i and j. A drip adds three further dependent array reads to form z = S[j + S[i + S[z + k]]]. No read result is used as a read address in the same cycle, so the work is spread over six pipeline stages. During a whip the next update issues two cycles after the previous one, and the exchange in flight is forwarded to the next update's first read. During a drip one byte issues every three cycles, so the read of z never sees a stale value.

A caller picks an operation on `op_i`, gives a count on `count_i`, and pulses `start_i` while `busy_o` is low. Keystream bytes appear on `ks_o`, each marked by a single-cycle `ks_valid_o`. The registers i, j, k and w are brought out so their progress can be followed.

Top module: `ks_update_pipe`

## Requirements
- R1: After reset the array holds S[v] = v for every v, i = j = k = z = 0, w = 1, and `busy_o` and `ks_valid_o` are low.
- R2: Operation code 0 (initialize) keeps `busy_o` high for exactly N/4 cycles, loading four entries per cycle. It then leaves the state as in R1, whatever state came before.
- R3: Each update sets i = i + w, then j = k + S[j + S[i]], then k = i + k + S[j] with the new i, the old k and the new j. It then exchanges S[i] and S[j]. All arithmetic is modulo N.
- R4: Operation code 1 (whip) with count r performs r updates, issued two cycles apart. It then adds 2 to w once. `busy_o` stays high for exactly 2r+2 cycles, and w stays odd.
- R5: Operation code 2 (drip) with count n performs n update-then-output steps. Each step sets z = S[j + S[i + S[z + k]]], using the state after that step's update, and presents z on `ks_o`.
- R6: In a drip, byte number m (counting from 0) is marked by `ks_valid_o` for one cycle, 3m+6 clock edges after the edge that accepted the start. `busy_o` stays high for exactly 3n+3 cycles.
- R7: A start request is ignored while `busy_o` is high, and a start with operation code 3 is ignored at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| op_i | input | 2 | Operation: 0 initialize, 1 whip, 2 drip, 3 none |
| count_i | input | CNT_W | Number of updates (whip) or bytes (drip) |
| busy_o | output | 1 | High while an operation runs |
| ks_o | output | DW | Keystream byte (current z) |
| ks_valid_o | output | 1 | One-cycle strobe when a new byte is registered in z |
| i_o | output | DW | Current i |
| j_o | output | DW | Current j |
| k_o | output | DW | Current k |
| w_o | output | DW | Current w |

## Verification
The assertions assume the caller never changes `op_i` or `count_i` in the cycle a start is accepted. They also assume the array remains a permutation, which holds because writes come only from initialization and from exchanges. The bench drives a start only on the falling edge and drops it one cycle later. In the one test that pulses a start during a running operation, it checks through the state ports that the pulse changed nothing. The keystream checks run long whip and drip sequences against a sequential model of the state, and they cover the count values 0 and 1 as well as counts above N.

// File: rtl/ks_pkg.sv
package ks_pkg;
  typedef enum logic [1:0] {
    OP_INIT = 2'd0,
    OP_WHIP = 2'd1,
    OP_DRIP = 2'd2,
    OP_NONE = 2'd3
  } ks_op_e;
endpackage

// File: rtl/ks_perm_mem.sv
module ks_perm_mem #(
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int NRD   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     init_en_i,
  input  logic [DW-$clog2(LANES)-1:0] init_row_i,
  input  logic                     swap_en_i,
  input  logic [DW-1:0]            swap_a_i,
  input  logic [DW-1:0]            swap_da_i,
  input  logic [DW-1:0]            swap_b_i,
  input  logic [DW-1:0]            swap_db_i,
  input  logic [NRD-1:0][DW-1:0]   rd_addr_i,
  output logic [NRD-1:0][DW-1:0]   rd_data_o
);
  localparam int NE    = 2 ** DW;
  localparam int LW    = $clog2(LANES);
  localparam int ROW_W = DW - LW;

  logic [DW-1:0] mem_q [NE];

  for (genvar e = 0; e < NE; e++) begin : g_ent
    localparam logic [DW-1:0]    EA = DW'(e);
    localparam logic [ROW_W-1:0] ER = ROW_W'(e >> LW);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[e] <= EA;
      else if (init_en_i && init_row_i == ER)   mem_q[e] <= EA;
      else if (swap_en_i && swap_b_i == EA)     mem_q[e] <= swap_db_i;
      else if (swap_en_i && swap_a_i == EA)     mem_q[e] <= swap_da_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_addr_i[p]];
  end

  // R3
  swap_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en_i && !init_en_i |=> mem_q[$past(swap_b_i)] == $past(swap_db_i));
  // R2
  init_swap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_en_i && swap_en_i));
endmodule

// File: rtl/ks_issue_ctrl.sv
module ks_issue_ctrl
  import ks_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int CNT_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  ks_op_e                      op_i,
  input  logic [CNT_W-1:0]            count_i,
  output logic                        busy_o,
  output logic                        s1_fire_o,
  output logic                        w_bump_o,
  output logic                        init_en_o,
  output logic [DW-$clog2(LANES)-1:0] init_row_o,
  output logic                        drip_mode_o
);
  localparam int LW     = $clog2(LANES);
  localparam int ROW_W  = DW - LW;
  localparam int ROWS   = 2 ** ROW_W;
  localparam int LEFT_W = CNT_W + 3;

  ks_op_e             mode_q;
  logic [LEFT_W-1:0]  left_q, tot;
  logic [CNT_W-1:0]   iss_q;
  logic [1:0]         ph_q, ph_last;
  logic [ROW_W-1:0]   row_q;
  logic               accept;

  assign busy_o = (left_q != '0);
  assign accept = start_i && !busy_o && (op_i != OP_NONE);

  always_comb begin
    unique case (op_i)
      OP_INIT: tot = LEFT_W'(ROWS);
      OP_WHIP: tot = (LEFT_W'(count_i) << 1) + LEFT_W'(2);
      OP_DRIP: tot = LEFT_W'(count_i) + (LEFT_W'(count_i) << 1) + LEFT_W'(3);
      default: tot = '0;
    endcase
  end

  assign ph_last     = (mode_q == OP_DRIP) ? 2'd2 : 2'd1;
  assign s1_fire_o   = busy_o && (iss_q != '0) && (ph_q == 2'd0);
  assign w_bump_o    = busy_o && (mode_q == OP_WHIP) && (left_q == LEFT_W'(1));
  assign init_en_o   = busy_o && (mode_q == OP_INIT);
  assign init_row_o  = row_q;
  assign drip_mode_o = (mode_q == OP_DRIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OP_NONE;
      left_q <= '0;
      iss_q  <= '0;
      ph_q   <= '0;
      row_q  <= '0;
    end else if (accept) begin
      mode_q <= op_i;
      left_q <= tot;
      iss_q  <= (op_i == OP_INIT) ? '0 : count_i;
      ph_q   <= '0;
      row_q  <= '0;
    end else if (busy_o) begin
      left_q <= left_q - LEFT_W'(1);
      if (mode_q == OP_INIT) row_q <= row_q + ROW_W'(1);
      if (iss_q != '0) ph_q <= (ph_q == ph_last) ? 2'd0 : ph_q + 2'd1;
      if (s1_fire_o) iss_q <= iss_q - CNT_W'(1);
    end
  end

  // R4
  issue_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_fire_o |=> !s1_fire_o);
  // R6
  drip_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_fire_o && drip_mode_o |=> !s1_fire_o);
  // R2
  init_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_en_o |-> !s1_fire_o && !w_bump_o);
endmodule

// File: rtl/ks_out_stage.sv
module ks_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          go_i,
  input  logic [DW-1:0] i_i,
  input  logic [DW-1:0] j_i,
  input  logic [DW-1:0] k_i,
  output logic [DW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] z_o,
  output logic          valid_o
);
  logic          s5_v, s6_v, vld_q;
  logic [DW-1:0] t6_q, j5_q, t7_q, z_q;

  // one dependent read per stage: S[z+k], S[t6], S[t7]
  assign rd_addr_o = s6_v ? t7_q : (s5_v ? t6_q : z_q + k_i);
  assign z_o       = z_q;
  assign valid_o   = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s5_v  <= 1'b0;
      s6_v  <= 1'b0;
      vld_q <= 1'b0;
      t6_q  <= '0;
      j5_q  <= '0;
      t7_q  <= '0;
      z_q   <= '0;
    end else begin
      s5_v  <= go_i;
      s6_v  <= s5_v;
      vld_q <= s6_v;
      if (go_i) begin
        t6_q <= i_i + rd_data_i;
        j5_q <= j_i;
      end
      if (s5_v) t7_q <= j5_q + rd_data_i;
      if (clr_i)     z_q <= '0;
      else if (s6_v) z_q <= rd_data_i;
    end
  end

  // R6
  out_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !s5_v && !s6_v);
  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/ks_update_pipe.sv
module ks_update_pipe
  import ks_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic [DW-1:0]    ks_o,
  output logic             ks_valid_o,
  output logic [DW-1:0]    i_o,
  output logic [DW-1:0]    j_o,
  output logic [DW-1:0]    k_o,
  output logic [DW-1:0]    w_o
);
  localparam int NRD   = 4;
  localparam int ROW_W = DW - $clog2(LANES);

  logic               s1_fire, w_bump, init_en, drip_mode;
  logic [ROW_W-1:0]   init_row;
  logic [NRD-1:0][DW-1:0] rd_addr, rd_data;

  logic [DW-1:0] i_q, j_q, k_q, w_q;
  logic          s2_v, s3_v, s4_v;
  logic [DW-1:0] s2_i, s2_a, s3_i, s3_j, s3_si, s3_kp;
  logic [DW-1:0] i_nxt, s1_si, out_addr;

  ks_issue_ctrl #(.DW(DW), .LANES(LANES), .CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (ks_op_e'(op_i)),
    .count_i     (count_i),
    .busy_o      (busy_o),
    .s1_fire_o   (s1_fire),
    .w_bump_o    (w_bump),
    .init_en_o   (init_en),
    .init_row_o  (init_row),
    .drip_mode_o (drip_mode)
  );

  ks_perm_mem #(.DW(DW), .LANES(LANES), .NRD(NRD)) i_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_en_i  (init_en),
    .init_row_i (init_row),
    .swap_en_i  (s3_v),
    .swap_a_i   (s3_i),
    .swap_da_i  (rd_data[1]),
    .swap_b_i   (s3_j),
    .swap_db_i  (s3_si),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  ks_out_stage #(.DW(DW)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (init_en),
    .go_i      (s4_v),
    .i_i       (i_q),
    .j_i       (j_q),
    .k_i       (k_q),
    .rd_addr_o (out_addr),
    .rd_data_i (rd_data[3]),
    .z_o       (ks_o),
    .valid_o   (ks_valid_o)
  );

  // stage 1: new i, read S[i] with the in-flight exchange forwarded
  assign i_nxt = i_q + w_q;
  always_comb begin
    if (s3_v && i_nxt == s3_j)      s1_si = s3_si;
    else if (s3_v && i_nxt == s3_i) s1_si = rd_data[1];
    else                            s1_si = rd_data[0];
  end

  assign rd_addr[0] = i_nxt;
  assign rd_addr[1] = s3_v ? s3_j : s2_a;  // stage 3 / stage 2 never overlap
  assign rd_addr[2] = s2_i;
  assign rd_addr[3] = out_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q <= '0; j_q <= '0; k_q <= '0; w_q <= DW'(1);
      s2_v <= 1'b0; s3_v <= 1'b0; s4_v <= 1'b0;
      s2_i <= '0; s2_a <= '0;
      s3_i <= '0; s3_j <= '0; s3_si <= '0; s3_kp <= '0;
    end else begin
      s2_v <= s1_fire;
      s3_v <= s2_v;
      s4_v <= s3_v && drip_mode;
      if (init_en) begin
        i_q <= '0; j_q <= '0; k_q <= '0; w_q <= DW'(1);
      end else begin
        if (s1_fire) begin
          i_q  <= i_nxt;
          s2_i <= i_nxt;
          s2_a <= j_q + s1_si;
        end
        if (s2_v) begin
          j_q   <= k_q + rd_data[1];
          s3_j  <= k_q + rd_data[1];
          s3_i  <= s2_i;
          s3_si <= rd_data[2];
          s3_kp <= s2_i + k_q;
        end
        if (s3_v)   k_q <= s3_kp + rd_data[1];
        if (w_bump) w_q <= w_q + DW'(2);
      end
    end
  end

  assign i_o = i_q;
  assign j_o = j_q;
  assign k_o = k_q;
  assign w_o = w_q;

  // R4
  w_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_q[0]);
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$past(busy_o) |-> $past(start_i));
  // R4
  w_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(w_q) || busy_o);
endmodule

// File: tb/test_ks_update_pipe.sv
`timescale 1ns/1ps
module test_ks_update_pipe;
  localparam int DW = 8;
  localparam int NN = 256;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'd3;
  logic [CW-1:0] count_i = '0;
  logic          busy_o, ks_valid_o;
  logic [DW-1:0] ks_o, i_o, j_o, k_o, w_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] ms [NN];
  logic [7:0] mi, mj, mk, mw, mz;
  logic [7:0] exp_b [1024];

  always #2.5 clk = ~clk;

  ks_update_pipe #(.DW(DW), .LANES(4), .CNT_W(CW)) i_ks_update_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .count_i(count_i), .busy_o(busy_o), .ks_o(ks_o), .ks_valid_o(ks_valid_o),
    .i_o(i_o), .j_o(j_o), .k_o(k_o), .w_o(w_o));

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic m_init();
    for (int v = 0; v < NN; v++) ms[v] = 8'(v);
    mi = 0; mj = 0; mk = 0; mz = 0; mw = 1;
  endtask

  task automatic m_update();
    logic [7:0] t;
    mi = mi + mw;
    mj = mk + ms[8'(mj + ms[mi])];
    mk = mi + mk + ms[mj];
    t = ms[mi]; ms[mi] = ms[mj]; ms[mj] = t;
  endtask

  task automatic m_output();
    mz = ms[8'(mj + ms[8'(mi + ms[8'(mz + mk)])])];
  endtask

  task automatic check_state(input string req);
    chk(req, i_o, mi, "i");
    chk(req, j_o, mj, "j");
    chk(req, k_o, mk, "k");
    chk(req, w_o, mw, "w");
  endtask

  // op: 0 init, 1 whip, 2 drip, 3 none; poke pulses an init start mid-run
  task automatic run_op(input logic [1:0] op, input int cnt, input bit poke);
    int len, idx;
    bit busy_bad;
    string rq;
    len = (op == 2'd0) ? NN/4 : (op == 2'd1) ? 2*cnt+2 : (op == 2'd2) ? 3*cnt+3 : 0;
    rq = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R4" : (op == 2'd2) ? "R6" : "R7";
    if (op == 2'd0) m_init();
    else if (op == 2'd1) begin
      for (int u = 0; u < cnt; u++) m_update();
      mw = mw + 8'd2;
    end else if (op == 2'd2) begin
      for (int u = 0; u < cnt; u++) begin m_update(); m_output(); exp_b[u] = mz; end
    end
    @(negedge clk);
    op_i = op; count_i = CW'(cnt); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; busy_bad = 1'b0;
    if (busy_o != (len > 0)) busy_bad = 1'b1;
    for (int m = 1; m <= len + 3; m++) begin
      if (poke && m == 3) begin op_i = 2'd0; start_i = 1'b1; end
      else start_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (busy_o != (m < len)) busy_bad = 1'b1;
      if (ks_valid_o) begin
        // R6 byte timing, R5 byte value
        chk("R6", (op == 2'd2 && idx < cnt) ? m : -1, 3*idx+6, "valid edge");
        chk("R5", ks_o, exp_b[idx], "keystream byte");
        idx++;
      end
    end
    start_i = 1'b0;
    chk(rq, busy_bad, 0, "busy length");
    if (op == 2'd2) chk("R6", idx, cnt, "byte count");
    else chk(rq, idx, 0, "unexpected valid");
  endtask

  initial begin
    m_init();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", busy_o, 0, "busy after reset");
    chk("R1", ks_valid_o, 0, "valid after reset");
    check_state("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    run_op(2'd2, 8, 1'b0);          // R1 identity array, R5 drip from reset
    check_state("R3");
    run_op(2'd1, 0, 1'b0);          // R4 count zero
    check_state("R4");
    run_op(2'd1, 1, 1'b0);
    check_state("R3");
    run_op(2'd1, 7, 1'b0);
    check_state("R3");
    run_op(2'd1, 40, 1'b0);
    check_state("R4");
    run_op(2'd2, 1, 1'b0);
    run_op(2'd2, 300, 1'b0);
    check_state("R5");
    run_op(2'd1, 9, 1'b1);          // R7 start during busy ignored
    check_state("R7");
    run_op(2'd3, 5, 1'b0);          // R7 op 3 ignored
    check_state("R7");
    run_op(2'd0, 0, 1'b0);          // R2 init
    check_state("R2");
    run_op(2'd2, 20, 1'b0);         // R2 array and z restored
    run_op(2'd1, 2*NN, 1'b0);       // R3 long whip
    check_state("R3");
    run_op(2'd2, 50, 1'b0);
    check_state("R5");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule